// File: doc/BRIEF.md
# Audio Effects DSP Multiply-Accumulate Step

This block performs the arithmetic of one instruction step in a microprogrammed audio effects processor. Each enabled clock cycle it takes decoded instruction fields and builds three operands. The first is a 24-bit input picked from one of three source banks: memory-read values, mixer channels or external channels. The second and third are an X factor and a B addend, each taken either from a circular scratch RAM or from the running accumulator. A 13-bit Y factor comes from a fraction register, a coefficient word or a latched input register. The block multiplies X by Y, scales the product down and adds B, which gives a new 26-bit accumulator.

The source banks, the scratch RAM and the coefficient store sit outside the block. The block drives their read indices and takes back their read data in the same cycle. The scratch RAM is addressed relative to a ring counter that the sequencer decrements once per frame. A frame-start strobe clears the running state so that the first step of a frame sees zeros. The fraction register is loaded through a write port by the downstream shifter stage. The registered accumulator feeds that shifter.

Top module: `afx_mac_step`

## Requirements
- R1: The 24-bit input is chosen by `src_idx`. Values 0..31 give `mems_rdata` unchanged, with `mems_idx = src_idx`. Values 32..47 give `mixs_rdata` shifted left by 4, with `mixs_idx = src_idx-32`. Values 48..49 give `exts_rdata` shifted left by 8, with `exts_idx = src_idx-48`. Values 50..63 give zero. The result is treated as signed with bit 23 as its sign.
- R2: `temp_raddr` equals `(tra + ring_ct) mod 128`. The scratch word that comes back is sign-extended from bit 23.
- R3: B is zero when `zero`=1. Otherwise B is the current accumulator when `bsel`=1, or the scratch word when `bsel`=0. When `negb`=1 and `zero`=0, B is negated (mod 2^26).
- R4: X is the selected input when `xsel`=1 and the scratch word when `xsel`=0.
- R5: The `ysel` field picks Y as follows, each value signed:
  - `ysel`=0: the 13-bit fraction register.
  - `ysel`=1: `coef_rdata[15:3]`, where `coef_addr = step_idx`.
  - `ysel`=2: the latched input register bits [23:11].
  - `ysel`=3: the latched input register bits [15:4], 12 bits sign-extended.
- R6: On a step with `yrl`=1, the latched input register (`yreg_o`) takes the selected input. Y in that same step still uses the old register value. `frac_wr` loads `frac_wdata` into the fraction register, and Y first uses the new value on the following step.
- R7: The new accumulator is the full signed product X*Y, shifted arithmetically right by 10 and wrapped to 26 bits. With `zero`=1 this value is the accumulator. Otherwise B is added and the sum is wrapped to 26 bits.
- R8: `frame_start` clears the accumulator, the latched input register and the fraction register. When it comes with `step_en`, the step computes as if these already held zero. A `frac_wr` in the same cycle takes priority over the clear.
- R9: With `step_en`=0 and `frame_start`=0, `acc_o` and `yreg_o` keep their values whatever the instruction fields hold.
- R10: `acc_o` and `yreg_o` are registers. They reset to zero and show a step's result from the clock edge that ends that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Execute one step this cycle |
| frame_start | input | 1 | First cycle of a frame; clears running state |
| step_idx | input | 7 | Step number within the frame |
| src_idx | input | 6 | Input source index |
| xsel | input | 1 | X from input (1) or scratch (0) |
| yrl | input | 1 | Latch input into Y register |
| ysel | input | 2 | Y source select |
| zero | input | 1 | Force B to zero and skip the add |
| bsel | input | 1 | B from accumulator (1) or scratch (0) |
| negb | input | 1 | Negate B |
| tra | input | 7 | Scratch read offset |
| ring_ct | input | 7 | Per-frame ring counter |
| frac_wr | input | 1 | Load fraction register |
| frac_wdata | input | 13 | Fraction register load value |
| mems_idx | output | 5 | Memory-input bank read index |
| mems_rdata | input | 24 | Memory-input bank read data |
| mixs_idx | output | 4 | Mixer bank read index |
| mixs_rdata | input | 20 | Mixer bank read data |
| exts_idx | output | 1 | External bank read index |
| exts_rdata | input | 16 | External bank read data |
| temp_raddr | output | 7 | Scratch RAM read address |
| temp_rdata | input | 24 | Scratch RAM read data |
| coef_addr | output | 7 | Coefficient read address |
| coef_rdata | input | 16 | Coefficient read data |
| acc_o | output | 26 | Registered accumulator |
| yreg_o | output | 24 | Registered latched input |

## Verification
The read indices are combinational, so the bank contents are returned in the same cycle. A step whose inputs are driven before a rising edge shows its accumulator and latched-input result on `acc_o`/`yreg_o` right after that edge. The fraction write takes effect one step later. The bench drives inputs at the falling edge and updates its behavioural model at the rising edge. It compares both outputs at the next falling edge, so each result is checked exactly one edge after its step and again on every idle cycle that follows.

// File: rtl/afx_pkg.sv
package afx_pkg;

    localparam int AFX_DW  = 24;                 // input / scratch data width
    localparam int AFX_AW  = 26;                 // accumulator width
    localparam int AFX_YW  = 13;                 // Y factor width
    localparam int AFX_SHR = 10;                 // product scaling shift
    localparam int AFX_PW  = AFX_DW + AFX_YW;    // full product width

    typedef enum logic [1:0] {
        YS_FRAC = 2'd0,
        YS_COEF = 2'd1,
        YS_HIGH = 2'd2,
        YS_MID  = 2'd3
    } ysrc_e;

    typedef struct packed {
        logic [AFX_AW-1:0] acc;
        logic [AFX_DW-1:0] yreg;
        logic [AFX_YW-1:0] frac;
    } mac_state_t;

    function automatic logic [AFX_AW-1:0] sext_data(input logic [AFX_DW-1:0] v);
        return {{(AFX_AW-AFX_DW){v[AFX_DW-1]}}, v};
    endfunction

endpackage

// File: rtl/afx_src_mux.sv
module afx_src_mux #(
    parameter int MEMS_N = 32,
    parameter int MIXS_N = 16,
    parameter int EXTS_N = 2,
    parameter int MIXS_W = 20,
    parameter int EXTS_W = 16,
    parameter int IDX_W  = 6,
    parameter int DW     = 24,
    localparam int MEMS_AW = $clog2(MEMS_N),
    localparam int MIXS_AW = $clog2(MIXS_N),
    localparam int EXTS_AW = (EXTS_N > 1) ? $clog2(EXTS_N) : 1
) (
    input  logic [IDX_W-1:0]   src_idx,
    output logic [MEMS_AW-1:0] mems_idx,
    input  logic [DW-1:0]      mems_rdata,
    output logic [MIXS_AW-1:0] mixs_idx,
    input  logic [MIXS_W-1:0]  mixs_rdata,
    output logic [EXTS_AW-1:0] exts_idx,
    input  logic [EXTS_W-1:0]  exts_rdata,
    output logic [DW-1:0]      src_val
);
    localparam int MIX_BASE = MEMS_N;
    localparam int EXT_BASE = MEMS_N + MIXS_N;
    localparam int EXT_END  = EXT_BASE + EXTS_N;

    logic [IDX_W-1:0] rel_mix;
    logic [IDX_W-1:0] rel_ext;
    logic [DW-1:0]    mix_aligned;
    logic [DW-1:0]    ext_aligned;

    assign rel_mix  = src_idx - IDX_W'(MIX_BASE);
    assign rel_ext  = src_idx - IDX_W'(EXT_BASE);
    assign mems_idx = src_idx[MEMS_AW-1:0];
    assign mixs_idx = rel_mix[MIXS_AW-1:0];
    assign exts_idx = rel_ext[EXTS_AW-1:0];

    // narrow banks are left-aligned into the data width
    generate
        if (MIXS_W < DW) begin : g_mix_pad
            assign mix_aligned = {mixs_rdata, {(DW-MIXS_W){1'b0}}};
        end else begin : g_mix_full
            assign mix_aligned = mixs_rdata[MIXS_W-1 -: DW];
        end
        if (EXTS_W < DW) begin : g_ext_pad
            assign ext_aligned = {exts_rdata, {(DW-EXTS_W){1'b0}}};
        end else begin : g_ext_full
            assign ext_aligned = exts_rdata[EXTS_W-1 -: DW];
        end
    endgenerate

    always_comb begin
        if (src_idx < IDX_W'(MIX_BASE))
            src_val = mems_rdata;
        else if (src_idx < IDX_W'(EXT_BASE))
            src_val = mix_aligned;
        else if (src_idx < IDX_W'(EXT_END))
            src_val = ext_aligned;
        else
            src_val = '0;
    end

endmodule

// File: rtl/afx_operand_sel.sv
module afx_operand_sel
    import afx_pkg::*;
#(
    parameter int TEMP_N = 128,
    parameter int COEF_W = 16,
    localparam int TAW = $clog2(TEMP_N)
) (
    input  logic [TAW-1:0]    tra,
    input  logic [TAW-1:0]    ring_ct,
    output logic [TAW-1:0]    temp_raddr,
    input  logic [AFX_DW-1:0] temp_rdata,
    input  logic [AFX_DW-1:0] src_val,
    input  logic [AFX_AW-1:0] acc_cur,
    input  logic [AFX_DW-1:0] yreg_cur,
    input  logic [AFX_YW-1:0] frac_cur,
    input  logic [COEF_W-1:0] coef_rdata,
    input  logic              xsel,
    input  logic              bsel,
    input  logic              negb,
    input  logic              zero,
    input  logic [1:0]        ysel,
    output logic [AFX_AW-1:0] b_op,
    output logic [AFX_DW-1:0] x_op,
    output logic [AFX_YW-1:0] y_op
);
    localparam int YHI_LO  = AFX_DW - AFX_YW;     // bit 11
    localparam int YMID_LO = 4;
    localparam int YMID_W  = AFX_YW - 1;          // 12 bits
    localparam int COEF_LO = COEF_W - AFX_YW;     // bit 3

    logic [AFX_AW-1:0] temp_wide;
    logic [AFX_AW-1:0] b_raw;
    logic [YMID_W-1:0] y_mid;
    ysrc_e             ysrc;
    logic              unused_bits;

    assign temp_raddr = tra + ring_ct;            // wraps modulo the depth
    assign temp_wide  = sext_data(temp_rdata);
    assign y_mid      = yreg_cur[YMID_LO +: YMID_W];
    assign ysrc       = ysrc_e'(ysel);
    assign unused_bits = ^{coef_rdata[COEF_LO-1:0], yreg_cur[YMID_LO-1:0]};

    always_comb begin
        b_raw = bsel ? acc_cur : temp_wide;
        if (zero)
            b_op = '0;
        else if (negb)
            b_op = '0 - b_raw;
        else
            b_op = b_raw;
    end

    assign x_op = xsel ? src_val : temp_rdata;

    always_comb begin
        unique case (ysrc)
            YS_FRAC: y_op = frac_cur;
            YS_COEF: y_op = coef_rdata[COEF_W-1:COEF_LO];
            YS_HIGH: y_op = yreg_cur[AFX_DW-1:YHI_LO];
            YS_MID:  y_op = {y_mid[YMID_W-1], y_mid};
            default: y_op = '0;
        endcase
    end

endmodule

// File: rtl/afx_mac_core.sv
module afx_mac_core
    import afx_pkg::*;
(
    input  logic [AFX_DW-1:0] x_op,
    input  logic [AFX_YW-1:0] y_op,
    input  logic [AFX_AW-1:0] b_op,
    input  logic              zero,
    output logic [AFX_AW-1:0] acc_next
);
    logic signed [AFX_PW-1:0] prod;
    logic signed [AFX_PW-1:0] scaled;
    logic        [AFX_AW-1:0] prod_w;
    logic                     unused_hi;

    // full-width signed product: no overflow ahead of the shift
    assign prod      = AFX_PW'($signed(x_op)) * AFX_PW'($signed(y_op));
    assign scaled    = prod >>> AFX_SHR;
    assign prod_w    = scaled[AFX_AW-1:0];
    assign unused_hi = ^scaled[AFX_PW-1:AFX_AW];

    always_comb begin
        if (zero)
            acc_next = prod_w;
        else
            acc_next = prod_w + b_op;             // wraps to accumulator width
    end

endmodule

// File: rtl/afx_mac_step.sv
module afx_mac_step
    import afx_pkg::*;
#(
    parameter int MEMS_N = 32,
    parameter int MIXS_N = 16,
    parameter int EXTS_N = 2,
    parameter int MIXS_W = 20,
    parameter int EXTS_W = 16,
    parameter int TEMP_N = 128,
    parameter int STEPS  = 128,
    parameter int COEF_W = 16,
    localparam int IDX_W   = $clog2(MEMS_N + MIXS_N + EXTS_N + 1),
    localparam int MEMS_AW = $clog2(MEMS_N),
    localparam int MIXS_AW = $clog2(MIXS_N),
    localparam int EXTS_AW = (EXTS_N > 1) ? $clog2(EXTS_N) : 1,
    localparam int TAW     = $clog2(TEMP_N),
    localparam int SAW     = $clog2(STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               frame_start,
    input  logic [SAW-1:0]     step_idx,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic               xsel,
    input  logic               yrl,
    input  logic [1:0]         ysel,
    input  logic               zero,
    input  logic               bsel,
    input  logic               negb,
    input  logic [TAW-1:0]     tra,
    input  logic [TAW-1:0]     ring_ct,
    input  logic               frac_wr,
    input  logic [AFX_YW-1:0]  frac_wdata,
    output logic [MEMS_AW-1:0] mems_idx,
    input  logic [AFX_DW-1:0]  mems_rdata,
    output logic [MIXS_AW-1:0] mixs_idx,
    input  logic [MIXS_W-1:0]  mixs_rdata,
    output logic [EXTS_AW-1:0] exts_idx,
    input  logic [EXTS_W-1:0]  exts_rdata,
    output logic [TAW-1:0]     temp_raddr,
    input  logic [AFX_DW-1:0]  temp_rdata,
    output logic [SAW-1:0]     coef_addr,
    input  logic [COEF_W-1:0]  coef_rdata,
    output logic [AFX_AW-1:0]  acc_o,
    output logic [AFX_DW-1:0]  yreg_o
);
    mac_state_t        st_q, st_d;
    logic [AFX_DW-1:0] src_val;
    logic [AFX_AW-1:0] acc_cur;
    logic [AFX_DW-1:0] yreg_cur;
    logic [AFX_YW-1:0] frac_cur;
    logic [AFX_AW-1:0] b_op;
    logic [AFX_DW-1:0] x_op;
    logic [AFX_YW-1:0] y_op;
    logic [AFX_AW-1:0] acc_next;

    assign coef_addr = step_idx;

    // a frame start makes this step see cleared running state
    assign acc_cur  = frame_start ? '0 : st_q.acc;
    assign yreg_cur = frame_start ? '0 : st_q.yreg;
    assign frac_cur = frame_start ? '0 : st_q.frac;

    afx_src_mux #(
        .MEMS_N (MEMS_N),
        .MIXS_N (MIXS_N),
        .EXTS_N (EXTS_N),
        .MIXS_W (MIXS_W),
        .EXTS_W (EXTS_W),
        .IDX_W  (IDX_W),
        .DW     (AFX_DW)
    ) u_src (
        .src_idx    (src_idx),
        .mems_idx   (mems_idx),
        .mems_rdata (mems_rdata),
        .mixs_idx   (mixs_idx),
        .mixs_rdata (mixs_rdata),
        .exts_idx   (exts_idx),
        .exts_rdata (exts_rdata),
        .src_val    (src_val)
    );

    afx_operand_sel #(
        .TEMP_N (TEMP_N),
        .COEF_W (COEF_W)
    ) u_opsel (
        .tra        (tra),
        .ring_ct    (ring_ct),
        .temp_raddr (temp_raddr),
        .temp_rdata (temp_rdata),
        .src_val    (src_val),
        .acc_cur    (acc_cur),
        .yreg_cur   (yreg_cur),
        .frac_cur   (frac_cur),
        .coef_rdata (coef_rdata),
        .xsel       (xsel),
        .bsel       (bsel),
        .negb       (negb),
        .zero       (zero),
        .ysel       (ysel),
        .b_op       (b_op),
        .x_op       (x_op),
        .y_op       (y_op)
    );

    afx_mac_core u_mac (
        .x_op     (x_op),
        .y_op     (y_op),
        .b_op     (b_op),
        .zero     (zero),
        .acc_next (acc_next)
    );

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.acc  = '0;
            st_d.yreg = '0;
            st_d.frac = '0;
        end
        if (step_en) begin
            st_d.acc  = acc_next;
            st_d.yreg = yrl ? src_val : yreg_cur;
        end
        if (frac_wr)
            st_d.frac = frac_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign yreg_o = st_q.yreg;

endmodule

// File: rtl/afx_mac_step_chk.sv
module afx_mac_step_chk #(
    parameter int IDX_W     = 6,
    parameter int NULL_BASE = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             frame_start,
    input logic             yrl,
    input logic             zero,
    input logic             xsel,
    input logic [IDX_W-1:0] src_idx,
    input logic [23:0]      src_val,
    input logic [25:0]      acc_o,
    input logic [23:0]      yreg_o
);

    // R9: idle cycles leave both registers untouched
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !frame_start) |=> ($stable(acc_o) && $stable(yreg_o)));

    // R8: a lone frame start clears the visible state
    a_r8_lone_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !step_en) |=> (acc_o == '0 && yreg_o == '0));

    // R8: a first step without a latch leaves the Y register cleared
    a_r8_yreg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && step_en && !yrl) |=> (yreg_o == '0));

    // R6: the latch captures the selected input
    a_r6_yreg_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && yrl) |=> (yreg_o == $past(src_val)));

    // R1: indices past the last bank feed zero, so a product-only step gives zero
    a_r1_null_input: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && zero && xsel && src_idx >= IDX_W'(NULL_BASE)) |=> (acc_o == '0));

endmodule

bind afx_mac_step afx_mac_step_chk #(
    .IDX_W     (6),
    .NULL_BASE (50)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .frame_start (frame_start),
    .yrl         (yrl),
    .zero        (zero),
    .xsel        (xsel),
    .src_idx     (src_idx),
    .src_val     (src_val),
    .acc_o       (acc_o),
    .yreg_o      (yreg_o)
);

// File: tb/afx_mac_step_tb_top.sv
`timescale 1ns/1ps
module afx_mac_step_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0, frame_start = 1'b0;
    logic [6:0]  step_idx = '0;
    logic [5:0]  src_idx = '0;
    logic        xsel = 0, yrl = 0, zero = 0, bsel = 0, negb = 0;
    logic [1:0]  ysel = '0;
    logic [6:0]  tra = '0, ring_ct = '0;
    logic        frac_wr = 1'b0;
    logic [12:0] frac_wdata = '0;
    logic [4:0]  mems_idx;
    logic [3:0]  mixs_idx;
    logic [0:0]  exts_idx;
    logic [6:0]  temp_raddr, coef_addr;
    logic [25:0] acc_o;
    logic [23:0] yreg_o;

    logic [23:0] tb_mems [32];
    logic [19:0] tb_mixs [16];
    logic [15:0] tb_exts [2];
    logic [23:0] tb_temp [128];
    logic [15:0] tb_coef [128];

    int    total = 0, bad = 0;
    string cur_req = "R10", lat_req = "R10";
    longint m_acc = 0, m_yreg = 0, m_frac = 0;
    bit    done = 0;

    always #5 clk = ~clk;

    afx_mac_step dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .frame_start(frame_start),
        .step_idx(step_idx), .src_idx(src_idx), .xsel(xsel), .yrl(yrl), .ysel(ysel),
        .zero(zero), .bsel(bsel), .negb(negb), .tra(tra), .ring_ct(ring_ct),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .mems_idx(mems_idx), .mems_rdata(tb_mems[mems_idx]),
        .mixs_idx(mixs_idx), .mixs_rdata(tb_mixs[mixs_idx]),
        .exts_idx(exts_idx), .exts_rdata(tb_exts[exts_idx]),
        .temp_raddr(temp_raddr), .temp_rdata(tb_temp[temp_raddr]),
        .coef_addr(coef_addr), .coef_rdata(tb_coef[coef_addr]),
        .acc_o(acc_o), .yreg_o(yreg_o)
    );

    function automatic longint sx(input longint v, input int w);
        longint m = longint'(1) <<< w;
        longint r = v & (m - 1);
        if (r >= m / 2) r = r - m;
        return r;
    endfunction

    // behavioural reference, evaluated at each rising edge
    always @(posedge clk) begin : model
        longint inp, tv, acc_c, yr_c, fr_c, b, x, y, p;
        if (!rst_n) begin
            m_acc = 0; m_yreg = 0; m_frac = 0;
        end else begin
            if (src_idx < 32)      inp = sx(longint'(tb_mems[src_idx]), 24);
            else if (src_idx < 48) inp = sx(longint'(tb_mixs[src_idx-32]) <<< 4, 24);
            else if (src_idx < 50) inp = sx(longint'(tb_exts[src_idx-48]) <<< 8, 24);
            else                   inp = 0;
            tv    = sx(longint'(tb_temp[(int'(tra) + int'(ring_ct)) % 128]), 24);
            acc_c = frame_start ? 0 : m_acc;
            yr_c  = frame_start ? 0 : m_yreg;
            fr_c  = frame_start ? 0 : m_frac;
            if (zero) b = 0;
            else begin
                b = bsel ? sx(acc_c, 26) : tv;
                if (negb) b = -b;
            end
            x = xsel ? inp : tv;
            case (ysel)
                2'd0: y = sx(fr_c, 13);
                2'd1: y = sx(longint'(tb_coef[step_idx]) >>> 3, 13);
                2'd2: y = sx(yr_c >>> 11, 13);
                default: y = sx(yr_c >>> 4, 12);
            endcase
            p = sx((x * y) >>> 10, 26);
            if (step_en) begin
                m_acc  = zero ? p : sx(p + b, 26);
                m_yreg = yrl ? (inp & 64'hFFFFFF) : yr_c;
            end else if (frame_start) begin
                m_acc = 0; m_yreg = 0;
            end
            if (frac_wr) m_frac = longint'(frac_wdata);
            else         m_frac = fr_c;
        end
        lat_req = cur_req;
    end

    // compare on every falling edge
    always @(negedge clk) begin
        logic [25:0] ea;
        logic [23:0] ey;
        if (rst_n && !done) begin
            ea = m_acc[25:0];
            ey = m_yreg[23:0];
            total++;
            if (acc_o !== ea || yreg_o !== ey) begin
                bad++;
                $display("FAIL %s acc=%h exp=%h yreg=%h exp=%h", lat_req, acc_o, ea, yreg_o, ey);
            end
        end
    end

    task automatic step(input int src, input bit xs, input bit yr, input int ys,
                        input bit z, input bit bs, input bit nb, input int tr,
                        input int ct, input bit fs, input int st);
        @(negedge clk);
        step_en = 1; frame_start = fs; src_idx = 6'(src); xsel = xs; yrl = yr;
        ysel = 2'(ys); zero = z; bsel = bs; negb = nb; tra = 7'(tr);
        ring_ct = 7'(ct); step_idx = 7'(st);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_en = 0; frame_start = 0; frac_wr = 0;
            zero = ~zero; yrl = 1; src_idx = 6'(i);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 32; i++)  tb_mems[i] = 24'(i * 24'h01F3A7 + 24'h800000 * (i % 2));
        for (int i = 0; i < 16; i++)  tb_mixs[i] = 20'(i * 20'h0B3C1 + 20'h80000 * (i % 2));
        tb_exts[0] = 16'h1234; tb_exts[1] = 16'h8001;
        for (int i = 0; i < 128; i++) tb_temp[i] = 24'(i * 24'h0A1B2C + 24'h13);
        for (int i = 0; i < 128; i++) tb_coef[i] = 16'(i * 16'h3A1 + 16'h2000);
        tb_coef[1] = 16'h2000;                  // Y = 1024: acc equals X
        tb_coef[2] = 16'h8000;                  // Y = -4096

        repeat (3) @(posedge clk);
        #1;
        total++;                                // R10: reset state
        if (acc_o !== '0 || yreg_o !== '0) begin
            bad++;
            $display("FAIL R10 reset acc=%h exp=0 yreg=%h exp=0", acc_o, yreg_o);
        end
        @(negedge clk); rst_n = 1;

        cur_req = "R1";                         // each source range, product only
        step(3, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1);
        step(5, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(42, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(33, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(49, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(48, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(53, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
        step(63, 1, 0, 1, 1, 0, 0, 0, 0, 0, 1);

        cur_req = "R2";                         // scratch index wraps
        step(0, 0, 0, 1, 1, 0, 0, 100, 60, 0, 1);
        step(0, 0, 0, 1, 1, 0, 0, 127, 127, 0, 1);
        step(0, 0, 0, 1, 1, 0, 0, 0, 5, 0, 1);

        cur_req = "R4";                         // X from input vs scratch
        step(7, 1, 0, 1, 1, 0, 0, 9, 0, 0, 1);
        step(7, 0, 0, 1, 1, 0, 0, 9, 0, 0, 1);

        cur_req = "R3";                         // B variants
        step(7, 1, 0, 1, 0, 1, 0, 0, 0, 0, 1);
        step(7, 1, 0, 1, 0, 1, 1, 0, 0, 0, 1);
        step(7, 1, 0, 1, 0, 0, 0, 20, 3, 0, 1);
        step(7, 1, 0, 1, 0, 0, 1, 20, 3, 0, 1);
        step(7, 1, 0, 1, 1, 1, 1, 20, 3, 0, 1);

        cur_req = "R5";                         // every Y source
        step(9, 1, 1, 2, 1, 0, 0, 0, 0, 0, 1);
        step(9, 1, 1, 3, 1, 0, 0, 0, 0, 0, 1);
        step(11, 1, 0, 1, 1, 0, 0, 0, 0, 0, 40);
        @(negedge clk); step_en = 0; frac_wr = 1; frac_wdata = 13'h1ABC;
        step(11, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        frac_wr = 0;
        step(11, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1);

        cur_req = "R6";                         // latch uses old Y value first
        step(13, 1, 1, 2, 1, 0, 0, 0, 0, 0, 1);
        step(14, 1, 1, 2, 1, 0, 0, 0, 0, 0, 1);
        step(15, 1, 0, 3, 0, 1, 0, 0, 0, 0, 1);

        cur_req = "R7";                         // extremes and wrap
        tb_mems[20] = 24'h800000;
        step(20, 1, 0, 1, 1, 0, 0, 0, 0, 0, 2);
        step(20, 1, 0, 1, 0, 1, 0, 0, 0, 0, 2);
        step(20, 1, 0, 1, 0, 1, 1, 0, 0, 0, 2);
        tb_mems[21] = 24'h7FFFFF; tb_coef[3] = 16'h7FF8;
        step(21, 1, 0, 1, 0, 1, 0, 0, 0, 0, 3);
        step(21, 1, 0, 1, 0, 1, 0, 0, 0, 0, 3);

        cur_req = "R8";                         // frame start clears mid-run
        step(21, 1, 1, 1, 0, 1, 0, 0, 0, 0, 3);
        step(22, 1, 0, 2, 0, 1, 0, 0, 0, 1, 1);
        step(22, 1, 1, 1, 0, 1, 0, 0, 0, 0, 1);
        @(negedge clk); step_en = 0; frame_start = 1; frac_wr = 1; frac_wdata = 13'h0F0F;
        @(negedge clk); frame_start = 0; frac_wr = 0;
        step(23, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        @(negedge clk); step_en = 0; frame_start = 1;
        step(23, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1);

        cur_req = "R9";
        step(24, 1, 1, 1, 0, 1, 0, 0, 0, 0, 5);
        idle(6);

        cur_req = "R10";
        step(25, 1, 1, 1, 1, 0, 0, 0, 0, 0, 6);
        idle(2);

        cur_req = "R7";                         // random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0)
                tb_temp[$urandom_range(0, 127)] = 24'($urandom);
            step_en     = ($urandom_range(0, 9) != 0);
            frame_start = ($urandom_range(0, 40) == 0);
            src_idx = 6'($urandom); xsel = 1'($urandom); yrl = 1'($urandom);
            ysel = 2'($urandom); zero = 1'($urandom); bsel = 1'($urandom);
            negb = 1'($urandom); tra = 7'($urandom); ring_ct = 7'($urandom);
            step_idx = 7'($urandom);
            frac_wr = ($urandom_range(0, 5) == 0); frac_wdata = 13'($urandom);
        end
        idle(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule